// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer with Overlapped High-Bit Lookup

This block drives the shared address pins of a DRAM whose address is split into two equal halves sent one after the other. The half it already knows when a request arrives is its low-order part. It places that part on the pins at once as the row address and raises the row strobe. The high-order part comes from a base register lookup that runs alongside and takes a varying number of cycles. The block sends it in the column phase, so the lookup time overlaps the row phase instead of adding to it.

The block takes a request only while `req_ready` is high. It captures the lookup result on the one-cycle `lkp_valid` pulse. If the result has not arrived by the time the column phase is due, it holds the row phase with the row strobe still high. After the column strobe it releases both strobes, gives a one-cycle `done` pulse and keeps a fixed precharge gap before it takes the next request.

Top module: `dram_addr_mux`

## Requirements
- R1: While reset is held and just after it, `req_ready` is 1 and `row_stb`, `col_stb`, `done` and `dram_addr` are all 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle `dram_addr` carries `req_low`, `req_ready` is 0 and `row_stb` is still 0.
- R3: `row_stb` rises exactly one cycle after the row address first appears. The pins do not change on that cycle. `row_stb` then stays 1 through the whole column phase.
- R4: If `lkp_valid` is seen in the accept cycle, the row-address cycle or the first row-strobe cycle, no wait is inserted. The column address appears in the second cycle of `row_stb`.
- R5: If `lkp_valid` arrives later, the block waits with `row_stb` at 1 and the low-order bits on the pins. The column address appears in the cycle after the `lkp_valid` cycle.
- R6: During the column phase `dram_addr` carries the `lkp_high` value that was present on the first `lkp_valid` pulse after acceptance. Later changes of `lkp_high`, and further pulses, have no effect.
- R7: `col_stb` rises one cycle after the column address first appears and is 1 for exactly one cycle. After it, `row_stb` and `col_stb` both fall on the same edge.
- R8: `done` is a one-cycle pulse in the first cycle in which both strobes are low after `col_stb`.
- R9: After the strobes fall, `req_ready` stays 0 for PRE_CYC cycles (the `done` cycle included) and then returns to 1. `req_valid` asserted while `req_ready` is 0 is ignored.
- R10: A `lkp_valid` pulse while idle and without a request changes no output.
- R11: When neither the row phase nor the column phase is active, `dram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_low | input | PIN_W | Low-order address half, used as the row address |
| req_ready | output | 1 | Block idle and precharge complete |
| lkp_valid | input | 1 | One-cycle pulse: lookup result valid |
| lkp_high | input | PIN_W | High-order address half from the lookup |
| dram_addr | output | PIN_W | Multiplexed DRAM address pins |
| row_stb | output | 1 | Row strobe, active high |
| col_stb | output | 1 | Column strobe, active high |
| done | output | 1 | Access finished pulse |

## Verification
The lookup pulse is swept across every arrival point from the accept cycle to six cycles into the access. This separates the no-wait cases from each number of wait cycles, and it shows whether the column phase is timed from the lookup or from the row phase. Complementary, alternating and walking address patterns are used, with `lkp_high` changed after the pulse. These show that each half goes to the right phase and that the captured value, not the live input, is driven. Extra requests during the access and a lookup pulse while idle are also applied, to confirm that both are ignored.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_SETUP,
    ST_ROW_ACT,
    ST_WAIT,
    ST_COL_SETUP,
    ST_COL_ACT,
    ST_PRECH
  } dam_state_e;

  // high half usable this cycle: already held, or arriving now
  function automatic logic hi_usable(input logic held, input logic arriving);
    return held | arriving;
  endfunction

  // cycle index (0 = first cycle after accept) at which the column address
  // first appears, given the index at which the lookup pulse is seen
  // (-1 means the accept cycle itself)
  function automatic int col_phase_index(input int lkp_idx);
    return (lkp_idx < 2) ? 2 : lkp_idx + 1;
  endfunction

  // row phase still open to a lookup pulse
  function automatic logic listening(input dam_state_e st);
    return (st == ST_ROW_SETUP) || (st == ST_ROW_ACT) || (st == ST_WAIT);
  endfunction

endpackage

// File: rtl/dam_fsm.sv
module dam_fsm
  import dam_pkg::*;
#(
  parameter int PIN_W   = 10,
  parameter int PRE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PIN_W-1:0] req_low,
  input  logic             hi_avail,
  output dam_state_e       state,
  output logic [PIN_W-1:0] lo_q,
  output logic             accept,
  output logic             col_go,
  output logic             prech_first,
  output logic             prech_end
);
  localparam int PC_W = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRE_CYC - 1);

  dam_state_e      nxt;
  logic [PC_W-1:0] pcnt;

  assign accept      = (state == ST_IDLE) && req_valid;
  assign col_go      = ((state == ST_ROW_ACT) || (state == ST_WAIT)) && hi_avail;
  assign prech_first = (state == ST_PRECH) && (pcnt == '0);
  assign prech_end   = (state == ST_PRECH) && (pcnt == PC_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (accept) nxt = ST_ROW_SETUP;
      ST_ROW_SETUP: nxt = ST_ROW_ACT;
      ST_ROW_ACT:   nxt = col_go ? ST_COL_SETUP : ST_WAIT;
      ST_WAIT:      if (col_go) nxt = ST_COL_SETUP;
      ST_COL_SETUP: nxt = ST_COL_ACT;
      ST_COL_ACT:   nxt = ST_PRECH;
      ST_PRECH:     if (prech_end) nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pcnt  <= '0;
      lo_q  <= '0;
    end else begin
      state <= nxt;
      if (accept) lo_q <= req_low;
      if (state == ST_PRECH) pcnt <= prech_end ? '0 : pcnt + 1'b1;
      else                   pcnt <= '0;
    end
  end

endmodule

// File: rtl/dam_hi_hold.sv
module dam_hi_hold
  import dam_pkg::*;
#(
  parameter int PIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dam_state_e       state,
  input  logic             accept,
  input  logic             lkp_valid,
  input  logic [PIN_W-1:0] lkp_high,
  output logic [PIN_W-1:0] hi_q,
  output logic             hi_have
);
  logic take;

  assign take = listening(state) && lkp_valid && !hi_have;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      hi_have <= 1'b0;
    end else if (accept) begin
      hi_have <= lkp_valid;
      if (lkp_valid) hi_q <= lkp_high;
    end else if (take) begin
      hi_have <= 1'b1;
      hi_q    <= lkp_high;
    end
  end

endmodule

// File: rtl/dam_pin_drv.sv
module dam_pin_drv
  import dam_pkg::*;
#(
  parameter int PIN_W = 10
) (
  input  dam_state_e       state,
  input  logic [PIN_W-1:0] lo_q,
  input  logic [PIN_W-1:0] hi_q,
  input  logic             prech_first,
  output logic [PIN_W-1:0] dram_addr,
  output logic             row_stb,
  output logic             col_stb,
  output logic             done,
  output logic             req_ready
);
  always_comb begin
    dram_addr = '0;
    row_stb   = 1'b0;
    col_stb   = 1'b0;
    unique case (state)
      ST_ROW_SETUP: dram_addr = lo_q;
      ST_ROW_ACT,
      ST_WAIT: begin
        dram_addr = lo_q;
        row_stb   = 1'b1;
      end
      ST_COL_SETUP: begin
        dram_addr = hi_q;
        row_stb   = 1'b1;
      end
      ST_COL_ACT: begin
        dram_addr = hi_q;
        row_stb   = 1'b1;
        col_stb   = 1'b1;
      end
      default: ;
    endcase
  end

  assign done      = prech_first;
  assign req_ready = (state == ST_IDLE);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dam_pkg::*;
#(
  parameter int PIN_W   = 10,
  parameter int PRE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PIN_W-1:0] req_low,
  output logic             req_ready,
  input  logic             lkp_valid,
  input  logic [PIN_W-1:0] lkp_high,
  output logic [PIN_W-1:0] dram_addr,
  output logic             row_stb,
  output logic             col_stb,
  output logic             done
);
  dam_state_e       state;
  logic [PIN_W-1:0] lo_q;
  logic [PIN_W-1:0] hi_q;
  logic             hi_have;
  logic             hi_avail;
  logic             accept;
  logic             col_go;
  logic             prech_first;
  logic             prech_end;

  assign hi_avail = hi_usable(hi_have, lkp_valid);

  dam_fsm #(.PIN_W(PIN_W), .PRE_CYC(PRE_CYC)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_low     (req_low),
    .hi_avail    (hi_avail),
    .state       (state),
    .lo_q        (lo_q),
    .accept      (accept),
    .col_go      (col_go),
    .prech_first (prech_first),
    .prech_end   (prech_end)
  );

  dam_hi_hold #(.PIN_W(PIN_W)) i_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (accept),
    .lkp_valid (lkp_valid),
    .lkp_high  (lkp_high),
    .hi_q      (hi_q),
    .hi_have   (hi_have)
  );

  dam_pin_drv #(.PIN_W(PIN_W)) i_drv (
    .state       (state),
    .lo_q        (lo_q),
    .hi_q        (hi_q),
    .prech_first (prech_first),
    .dram_addr   (dram_addr),
    .row_stb     (row_stb),
    .col_stb     (col_stb),
    .done        (done),
    .req_ready   (req_ready)
  );

endmodule

// File: rtl/dam_chk.sv
module dam_chk #(
  parameter int PIN_W   = 10,
  parameter int PRE_CYC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [PIN_W-1:0] req_low,
  input logic             req_ready,
  input logic [PIN_W-1:0] dram_addr,
  input logic             row_stb,
  input logic             col_stb,
  input logic             done,
  input logic             col_go,
  input logic             prech_end
);
  localparam int GW = $clog2(PRE_CYC + 2);
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                        gap_cnt <= '0;
    else if (done)                     gap_cnt <= GW'(1);
    else if (!req_ready && gap_cnt != '0) gap_cnt <= gap_cnt + 1'b1;
    else if (req_ready)                gap_cnt <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !row_stb && dram_addr == $past(req_low)));

  assert_row_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb) |-> $stable(dram_addr));

  assert_col_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |-> row_stb);

  assert_col_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb) |-> ($stable(dram_addr) && $past(row_stb)));

  assert_col_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_stb |=> (!col_stb && !row_stb));

  assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(col_stb) && !row_stb && !col_stb));

  assert_col_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |=> (row_stb && !col_stb));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (gap_cnt == GW'(PRE_CYC) && $past(prech_end)));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!row_stb && !col_stb && !done));

  assert_pins_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_stb && !req_ready && $past(col_stb)) |-> (dram_addr == '0));

endmodule

bind dram_addr_mux dam_chk #(.PIN_W(PIN_W), .PRE_CYC(PRE_CYC)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_low   (req_low),
  .req_ready (req_ready),
  .dram_addr (dram_addr),
  .row_stb   (row_stb),
  .col_stb   (col_stb),
  .done      (done),
  .col_go    (col_go),
  .prech_end (prech_end)
);

// File: tb/test_dram_addr_mux.sv
module test_dram_addr_mux;
  localparam int CLK_PER = 10;
  localparam int PW      = 10;
  localparam int PC      = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [PW-1:0] req_low = '0;
  logic          req_ready;
  logic          lkp_valid = 1'b0;
  logic [PW-1:0] lkp_high = '0;
  logic [PW-1:0] dram_addr;
  logic          row_stb, col_stb, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  dram_addr_mux #(.PIN_W(PW), .PRE_CYC(PC)) i_dram_addr_mux (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_low(req_low),
    .req_ready(req_ready), .lkp_valid(lkp_valid), .lkp_high(lkp_high),
    .dram_addr(dram_addr), .row_stb(row_stb), .col_stb(col_stb), .done(done)
  );

  task automatic check_out(input string tag, input logic [PW-1:0] e_pins,
                           input logic e_row, input logic e_col,
                           input logic e_done, input logic e_rdy);
    logic [PW+3:0] act, exp;
    act = {dram_addr, row_stb, col_stb, done, req_ready};
    exp = {e_pins, e_row, e_col, e_done, e_rdy};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual pins=%h row=%b col=%b done=%b rdy=%b expected pins=%h row=%b col=%b done=%b rdy=%b",
               tag, dram_addr, row_stb, col_stb, done, req_ready,
               e_pins, e_row, e_col, e_done, e_rdy);
    end
  endtask

  // one access; lk = cycle index of lookup pulse (-1 = accept cycle)
  task automatic txn(input logic [PW-1:0] lo, input logic [PW-1:0] hi,
                     input int lk, input bit poke);
    int c, last;
    string tag;
    logic [PW-1:0] ep;
    c    = (lk < 2) ? 2 : lk + 1;
    last = c + 2 + PC;
    @(negedge clk);
    check_out("R9 ready before request", '0, 1'b0, 1'b0, 1'b0, 1'b1);
    req_valid = 1'b1;
    req_low   = lo;
    lkp_valid = (lk == -1);
    lkp_high  = (lk == -1) ? hi : ~hi;
    for (int idx = 0; idx <= last; idx++) begin
      @(negedge clk);
      req_valid = poke && (idx < last);
      req_low   = ~lo;
      lkp_valid = (idx == lk) || (poke && idx == lk + 1 && idx < c);
      lkp_high  = (idx == lk) ? hi : ~hi;
      ep = (idx < c) ? lo : ((idx < c + 2) ? hi : '0);
      if (idx == 0)                 tag = "R2 row address";
      else if (idx == 1)            tag = "R3 row strobe";
      else if (idx < c)             tag = "R5 wait";
      else if (idx == c && lk < 2)  tag = "R4 column no wait";
      else if (idx == c)            tag = "R6 column address";
      else if (idx == c + 1)        tag = "R7 column strobe";
      else if (idx == c + 2)        tag = "R8 done";
      else if (idx == last)         tag = "R9 ready again";
      else                          tag = "R11 R9 precharge";
      check_out(tag, ep, (idx >= 1) && (idx <= c + 1), idx == c + 1,
                idx == c + 2, idx >= last);
    end
    req_valid = 1'b0;
    lkp_valid = 1'b0;
  endtask

  initial begin
    repeat (CLK_PER * 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual no finish expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out("R1 in reset", '0, 1'b0, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after reset", '0, 1'b0, 1'b0, 1'b0, 1'b1);

    // R10: lookup pulse while idle
    lkp_valid = 1'b1;
    lkp_high  = 10'h0F0;
    @(negedge clk);
    lkp_valid = 1'b0;
    check_out("R10 idle lookup", '0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R10 idle lookup", '0, 1'b0, 1'b0, 1'b0, 1'b1);

    for (int lk = -1; lk <= 6; lk++) begin
      txn(10'h3FF, 10'h000, lk, 1'b0);
      txn(10'h155, 10'h2AA, lk, 1'b1);
      txn(PW'(10'h001 << (lk + 1)), PW'(10'h200 >> (lk + 1)), lk, lk[0]);
    end
    txn(10'h0AB, 10'h3C5, 9, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule